// File: doc/BRIEF.md
# Dual-Mode Interval Timer with Compare and PWM Output

This block is a 32-bit up-counting timer with a small word-addressed register bus. Software programs a reload value, a compare value and a control word. It then sets the start bit, and the counter advances on each functional-clock tick, either on every tick or at a power-of-two fraction of the tick rate. When the counter passes all-ones it overflows. In auto-reload mode it restarts from the reload value in that same cycle. Without auto-reload it wraps to zero and stops.

Overflow and compare-match events set sticky status flags, which software clears by writing one. Two separate mask registers turn these flags into an interrupt line and a wakeup line. The same events can also drive a single PWM pin, which either toggles or emits a one-cycle inverted pulse around a programmable idle level. A write of any value to a dedicated trigger address copies the reload value into the counter at once. The tick is an enable input sampled on the bus clock. Write posting belongs to a bridge outside the block.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads zero, and pwm_o, irq_o and wake_o are low. Word addresses: 0 control, 1 counter, 2 reload value, 3 compare value, 4 trigger (reads zero), 5 status, 6 interrupt mask, 7 wakeup mask. All reads are combinational.
- R2: Control bits: 0 start, 1 auto-reload, 4:2 prescale value, 5 prescale enable, 6 compare enable, 7 PWM idle level, 11:10 PWM event select, 12 toggle (1) / pulse (0). The counter advances only on a clock edge where start is 1 and tick_i is 1, subject to R5.
- R3: With auto-reload set, a step from 0xFFFFFFFF loads the reload value in that same edge, with no extra count, and sets status bit 1 (overflow).
- R4: With auto-reload clear, a step from 0xFFFFFFFF gives a counter of 0, clears the start bit, and sets status bit 1. The counter then holds.
- R5: With prescale enable set, the counter advances once every 2^(value+1) ticks. With prescale enable clear, it advances on every tick, whatever the prescale value.
- R6: With compare enable set, a step that makes the counter equal the compare value sets status bit 0 (match). With compare enable clear, no match is flagged.
- R7: A write to the trigger address, whatever the data, copies the reload value into the counter on that edge.
- R8: A direct write to the counter address takes priority over counting. The written value is read back, and counting continues from it.
- R9: Status bits are write-1-to-clear, and a new event in the same cycle wins over the clear. Bit 2 (capture) is always 0. irq_o is the OR of status AND interrupt mask, and wake_o is the OR of status AND wakeup mask.
- R10: Toggle mode: PWM event select 0 holds the pin at the idle level, 1 toggles it on overflow, and 2 or 3 toggles it on both overflow and match.
- R11: Pulse mode: the pin sits at the idle level and inverts for exactly one cycle after each selected event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Functional-clock tick enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Masked interrupt request |
| wake_o | output | 1 | Masked wakeup request |
| pwm_o | output | 1 | PWM / event output pin |

## Verification
A wrong prescaler or counter state shows up at the counter address as a value off by one or more steps within one tick of the fault. A wrong reload path at overflow appears as an extra count or a wrong value on the very next read after the wrap. Status or mask faults reach irq_o and wake_o in the cycle after the event or the clear. A lost or doubled event appears on pwm_o one edge after the event: as a missed toggle, or as a pulse that is missing or too wide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 32;
  localparam int PRE_W  = 3;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 13;
  localparam int STS_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd4;
  localparam logic [ADDR_W-1:0] A_STS  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;
  localparam logic [ADDR_W-1:0] A_WEN  = 3'd7;

  localparam int B_START = 0;
  localparam int B_AR    = 1;
  localparam int B_PS_LO = 2;
  localparam int B_PS_EN = 5;
  localparam int B_CE    = 6;
  localparam int B_DFLT  = 7;
  localparam int B_SEL   = 10;
  localparam int B_TOG   = 12;

  localparam int S_MAT = 0;
  localparam int S_OVF = 1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             step_o
);
  localparam int DIV_W = 1 << PRE_W;

  logic [DIV_W-1:0] div_q, mask;
  logic             term;

  // low (sel+1) bits all ones marks the last tick of a period
  assign mask   = ~({DIV_W{1'b1}} << ({1'b0, sel_i} + 1'b1));
  assign term   = (div_q & mask) == mask;
  assign step_o = run_i && tick_i && (!en_i || term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (!run_i || !en_i) div_q <= '0;
    else if (tick_i)         div_q <= term ? '0 : div_q + 1'b1;
  end

  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_o) |=> !(step_o && en_i && $stable(sel_i))); // R5
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ar_i,
  input  logic             ce_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             mat_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             adv;

  assign adv    = step_i && !wr_i && !trig_i;
  assign ovf_o  = adv && (&cnt_q);
  assign nxt    = (&cnt_q) ? (ar_i ? load_i : '0) : cnt_q + 1'b1;
  assign mat_o  = adv && ce_i && (nxt == cmp_i);
  assign stop_o = ovf_o && !ar_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (trig_i) cnt_q <= load_i;
    else if (adv)    cnt_q <= nxt;
  end

  AST_RELOAD_SAME_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && ar_i) |=> (cnt_q == $past(load_i))); // R3
  AST_ONESHOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ar_i) |=> (cnt_q == '0)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !wr_i && !trig_i) |=> $stable(cnt_q)); // R2
  AST_TRIG_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !wr_i) |=> (cnt_q == $past(load_i))); // R7
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovf_i,
  input  logic       mat_i,
  input  logic [1:0] sel_i,
  input  logic       dflt_i,
  input  logic       tog_i,
  output logic       pwm_o
);
  logic evt, lvl_q, pls_q;

  assign evt   = ((sel_i != 2'd0) && ovf_i) || (sel_i[1] && mat_i);
  assign pwm_o = tog_i ? lvl_q : (dflt_i ^ pls_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      pls_q <= evt && !tog_i;
      if (sel_i == 2'd0)      lvl_q <= dflt_i;
      else if (tog_i && evt)  lvl_q <= ~lvl_q;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pls_q && !(evt && !tog_i)) |=> !pls_q); // R11
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_i && evt && sel_i != 2'd0) |=> (lvl_q != $past(lvl_q))); // R10
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              pwm_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q, cmp_q, cnt;
  logic [STS_W-1:0]  sts_q, ien_q, wen_q, sts_set, sts_clr;
  logic              wr_ctrl, wr_cnt, wr_trig, step, ovf, mat, stop;

  assign wr_ctrl = we_i && addr_i == A_CTRL;
  assign wr_cnt  = we_i && addr_i == A_CNT;
  assign wr_trig = we_i && addr_i == A_TRIG;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i (ctrl_q[B_START]),
    .tick_i,
    .en_i  (ctrl_q[B_PS_EN]),
    .sel_i (ctrl_q[B_PS_LO +: PRE_W]),
    .step_o(step)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .step_i (step),
    .wr_i   (wr_cnt),
    .wdata_i,
    .trig_i (wr_trig),
    .load_i (load_q),
    .cmp_i  (cmp_q),
    .ar_i   (ctrl_q[B_AR]),
    .ce_i   (ctrl_q[B_CE]),
    .cnt_o  (cnt),
    .ovf_o  (ovf),
    .mat_o  (mat),
    .stop_o (stop)
  );

  tmr_pwm u_pwm (
    .clk_i, .rst_ni,
    .ovf_i (ovf),
    .mat_i (mat),
    .sel_i (ctrl_q[B_SEL +: 2]),
    .dflt_i(ctrl_q[B_DFLT]),
    .tog_i (ctrl_q[B_TOG]),
    .pwm_o
  );

  assign sts_set = {1'b0, ovf, mat};
  assign sts_clr = (we_i && addr_i == A_STS) ? wdata_i[STS_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      sts_q  <= '0;
      ien_q  <= '0;
      wen_q  <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (stop) ctrl_q[B_START] <= 1'b0;
      if (we_i && addr_i == A_LOAD) load_q <= wdata_i;
      if (we_i && addr_i == A_CMP)  cmp_q  <= wdata_i;
      if (we_i && addr_i == A_IEN)  ien_q  <= wdata_i[STS_W-1:0];
      if (we_i && addr_i == A_WEN)  wen_q  <= wdata_i[STS_W-1:0];
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  assign irq_o  = |(sts_q & ien_q);
  assign wake_o = |(sts_q & wen_q);

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_CNT:   rdata_o = cnt;
      A_LOAD:  rdata_o = load_q;
      A_CMP:   rdata_o = cmp_q;
      A_STS:   rdata_o = {{(CNT_W-STS_W){1'b0}}, sts_q};
      A_IEN:   rdata_o = {{(CNT_W-STS_W){1'b0}}, ien_q};
      A_WEN:   rdata_o = {{(CNT_W-STS_W){1'b0}}, wen_q};
      default: rdata_o = '0;
    endcase
  end

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !wr_ctrl) |=> !ctrl_q[B_START]); // R4
  AST_W1C_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr[S_OVF] && !ovf) |=> !sts_q[S_OVF]); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mat |=> sts_q[S_MAT]); // R6
  AST_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_q[2]); // R9
endmodule

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;
  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o, wake_o, pwm_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  pwm_timer u0 (.*);

  always #4 clk_i = ~clk_i;

  // {kind: 0 write / 1 read-check, addr, data}
  localparam logic [35:0] VEC [13] = '{
    {1'b0, 3'd2, 32'h0000_1234}, {1'b1, 3'd2, 32'h0000_1234},
    {1'b0, 3'd3, 32'hA5A5_0000}, {1'b1, 3'd3, 32'hA5A5_0000},
    {1'b0, 3'd1, 32'h0000_0077}, {1'b1, 3'd1, 32'h0000_0077},
    {1'b0, 3'd4, 32'hDEAD_BEEF}, {1'b1, 3'd1, 32'h0000_1234},
    {1'b1, 3'd4, 32'h0000_0000}, {1'b0, 3'd6, 32'hFFFF_FFFF},
    {1'b1, 3'd6, 32'h0000_0007}, {1'b0, 3'd0, 32'h0000_FFFF},
    {1'b1, 3'd0, 32'h0000_1FFF}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; #1;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i) tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl reset", v, 0);
    rd(3'd1, v); chk("R1 count reset", v, 0);
    rd(3'd5, v); chk("R1 status reset", v, 0);
    chk("R1 pins reset", {29'd0, pwm_o, irq_o, wake_o}, 0);

    // table walk: register access, trigger copy (R7), ctrl map (R2)
    for (int i = 0; i < 13; i++) begin
      if (!VEC[i][35]) wr(VEC[i][34:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][34:32], v);
        chk($sformatf("R7 R1 vector %0d", i), v, VEC[i][31:0]);
      end
    end
    wr(3'd0, 0); wr(3'd6, 0); wr(3'd5, 7);

    // R2 stopped counter ignores ticks
    wr(3'd1, 5); ticks(3);
    rd(3'd1, v); chk("R2 no count when stopped", v, 5);

    // R3 auto-reload
    wr(3'd2, 32'hFFFF_FFF0); wr(3'd1, 32'hFFFF_FFFD); wr(3'd0, 32'h3);
    ticks(3);
    rd(3'd1, v); chk("R3 reload value", v, 32'hFFFF_FFF0);
    rd(3'd5, v); chk("R3 overflow flag", v, 2);
    ticks(1);
    rd(3'd1, v); chk("R3 no extra count", v, 32'hFFFF_FFF1);
    rd(3'd0, v); chk("R3 still running", v, 3);

    // R9 masking and W1C
    chk("R9 irq masked", {31'd0, irq_o}, 0);
    wr(3'd6, 2); chk("R9 irq on", {31'd0, irq_o}, 1);
    wr(3'd7, 2); chk("R9 wake on", {31'd0, wake_o}, 1);
    wr(3'd5, 2); chk("R9 w1c", {30'd0, irq_o, wake_o}, 0);
    wr(3'd6, 0); wr(3'd7, 0);

    // R4 one-shot
    wr(3'd0, 0); wr(3'd1, 32'hFFFF_FFFE); wr(3'd0, 1);
    ticks(2);
    rd(3'd1, v); chk("R4 wraps to zero", v, 0);
    rd(3'd0, v); chk("R4 start cleared", v, 0);
    rd(3'd5, v); chk("R4 overflow flag", v, 2);
    ticks(3);
    rd(3'd1, v); chk("R4 holds after stop", v, 0);
    wr(3'd5, 7);

    // R5 prescaler: value 1 -> every 4 ticks
    wr(3'd1, 0); wr(3'd0, 32'h1 | (1 << 2) | (1 << 5));
    ticks(3); rd(3'd1, v); chk("R5 before period", v, 0);
    ticks(1); rd(3'd1, v); chk("R5 first step", v, 1);
    ticks(4); rd(3'd1, v); chk("R5 second step", v, 2);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd0, 32'h1 | (7 << 2));
    ticks(2); rd(3'd1, v); chk("R5 disabled every tick", v, 2);

    // R6 compare match
    wr(3'd0, 0); wr(3'd5, 7); wr(3'd1, 0); wr(3'd3, 5);
    wr(3'd0, 32'h1);
    ticks(5); rd(3'd5, v); chk("R6 no match when disabled", v, 0);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd0, 32'h1 | (1 << 6));
    ticks(4); rd(3'd5, v); chk("R6 not yet", v, 0);
    ticks(1); rd(3'd5, v); chk("R6 match flag", v, 1);
    rd(3'd1, v); chk("R6 count at match", v, 5);

    // R8 direct write while running
    wr(3'd0, 32'h3);
    @(negedge clk_i) tick_i = 1'b1;
    wr(3'd1, 100);
    rd(3'd1, v); chk("R8 write wins", v, 100);
    @(posedge clk_i); #1;
    rd(3'd1, v); chk("R8 counts on", v, 101);
    tick_i = 1'b0;

    // R10 toggle on overflow
    wr(3'd0, 0); wr(3'd5, 7); wr(3'd2, 32'hFFFF_FFFE); wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd0, 32'h1403);
    chk("R10 idle low", {31'd0, pwm_o}, 0);
    ticks(2); chk("R10 toggle 1", {31'd0, pwm_o}, 1);
    ticks(2); chk("R10 toggle 2", {31'd0, pwm_o}, 0);

    // R10 overflow and match select
    wr(3'd0, 0); wr(3'd3, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd0, 32'h1843);
    ticks(1); chk("R10 toggle on match", {31'd0, pwm_o}, 1);
    ticks(1); chk("R10 toggle on overflow", {31'd0, pwm_o}, 0);

    // R11 pulse mode, idle high
    wr(3'd0, 0); wr(3'd1, 32'hFFFF_FFFE); wr(3'd0, 32'h483);
    chk("R11 idle level", {31'd0, pwm_o}, 1);
    ticks(2); chk("R11 pulse", {31'd0, pwm_o}, 0);
    @(negedge clk_i); chk("R11 pulse one cycle", {31'd0, pwm_o}, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule